// File: doc/BRIEF.md
# Multi-Set Round-Robin Selector Pair for a Delayed Crossbar Scheduler

This block holds the input-side and output-side round-robin selectors of a crossbar scheduler. Request and grant results take several cell slots to travel between the two sides, and that delay is `RHO` slots. A selector that kept a single pointer would move it again before the result of its last decision came back. Those pointers would then stay in step with one another, and throughput would fall. To avoid this, every selector keeps `RHO` separate pointers. In any slot, one pointer set is active, and its index is the slot number modulo `RHO`.

In each slot, every input looks at its occupancy row and picks one target output, using the active request pointer. The request is tagged with the active set index. It then travels through a fixed channel of `RHO-1` register stages. At the far end, each output grants one of the inputs that requested it, using the grant pointer of the tagged set. In the same cycle, the grant decisions update only that set's grant pointers and the request pointers of the inputs that won. So each set's pointers have their new values exactly when that set becomes active again, `RHO` slots after it was last used. All sets share a single selection circuit per input and per output; a multiplexer picks the active set.

Top module: `mpsel_xbar_sched`

## Requirements
- R1: While `rst_n` is low at a clock edge, every request and grant pointer of every set is cleared to 0 and the channel is emptied. For the first `RHO-1` slots after reset, no grant is produced, and the first slot after reset uses set 0.
- R2: `req_set_o` gives the active set of the current slot. It steps by one in every slot after reset, going from `RHO-1` back to 0.
- R3: Input `i` raises `req_vld_o[i]` exactly when at least one bit of its occupancy row is set. The occupancy row is `occ_i[i*N +: N]`, and bit `j` means "has a cell for output `j`". Its target `req_tgt_o[i*IW +: IW]` is the first output `j` with its bit set, searching cyclically upward from the request pointer of the active set.
- R4: A request issued in slot `t` is presented to the output side in slot `t+RHO-1`. In that slot, `gnt_set_o` equals the set index the request carried, which is `(req_set_o + 1) mod RHO`.
- R5: Output `o` raises `gnt_vld_o[o]` when at least one arriving request targets it. It grants `gnt_src_o[o*IW +: IW]`, which is the first requesting input found by searching cyclically upward from the grant pointer of the tagged set.
- R6: Each input receives at most one grant per slot, and each output grants at most one input.
- R7: When output `o` grants, the grant pointer of the tagged set for `o` moves forward by one, modulo N. Pointers of other sets, and of outputs that did not grant, keep their values.
- R8: `won_o[i]` is high in the slot when a returning request of input `i` is granted. Only then does the request pointer of the tagged set for `i` move forward by one, modulo N.
- R9: A pointer update made from a slot's result is in place the next time the same set is active, `RHO` slots after the request that caused it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one cycle is one cell slot |
| rst_n | input | 1 | Synchronous reset, active low |
| occ_i | input | N*N | Occupancy; bit i*N+j set means input i holds a cell for output j |
| req_vld_o | output | N | Per input: a request is issued this slot |
| req_tgt_o | output | N*IW | Per input: target output index of the request |
| req_set_o | output | SW | Pointer set active for requests this slot |
| gnt_vld_o | output | N | Per output: a grant is issued this slot |
| gnt_src_o | output | N*IW | Per output: index of the granted input |
| gnt_set_o | output | SW | Set tag of the requests being answered this slot |
| won_o | output | N | Per input: its returning request was granted this slot |

## Verification
The assertions check the following on every cycle:
- the set index steps through its cycle;
- a request always points at an occupied output, and an input requests whenever its row is non-empty;
- no input collects two grants;
- grant tags trail the request tags by the channel delay;
- the number of winners matches the number of grants.

Cycle-by-cycle checks cannot show that each set keeps its own pointers and advances them only on its own results. The bench shows this with a reference model that keeps `RHO` independent pointer sets, driven by saturated, hot-spot, permutation and random traffic, with a mid-run reset.

// File: rtl/mpsel_pkg.sv
// Package: shared helpers for the multi-set selector.
// Assumes all operands are non-negative and smaller than the modulus.
package mpsel_pkg;

    // Cyclic addition of two indices modulo n.
    function automatic int wrap_add(input int a, input int b, input int n);
        return (a + b) % n;
    endfunction

endpackage

// File: rtl/mpsel_rr_pick.sv
// Module: round-robin picker.
// Finds the first set bit of req, searching cyclically upward from ptr.
// Assumes ptr < N. Purely combinational.
module mpsel_rr_pick #(
    parameter int N  = 4,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] ptr,
    output logic          hit,
    output logic [IW-1:0] idx
);

    // Scan the candidates in cyclic order and keep the first hit.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int k = 0; k < N; k++) begin
            int cand;
            cand = mpsel_pkg::wrap_add(int'(ptr), k, N);
            if (!hit && req[cand]) begin
                hit = 1'b1;
                idx = IW'(cand);
            end
        end
    end

endmodule

// File: rtl/mpsel_ptr_bank.sv
// Module: bank of RHO pointer sets, each with N pointers of IW bits.
// One read port selects a whole set for the shared selection logic.
// The write side moves chosen pointers of one set forward by one, modulo N.
// Assumes rd_set and wr_set are below RHO.
module mpsel_ptr_bank #(
    parameter int N   = 4,
    parameter int RHO = 4,
    parameter int IW  = $clog2(N),
    parameter int SW  = $clog2(RHO)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SW-1:0]   rd_set,
    output logic [N*IW-1:0] rd_ptr,
    input  logic [SW-1:0]   wr_set,
    input  logic [N-1:0]    wr_en
);

    logic [IW-1:0] ptr_q [RHO][N];

    // Clear all sets on reset; otherwise advance the enabled pointers of one set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < RHO; s++)
                for (int k = 0; k < N; k++)
                    ptr_q[s][k] <= '0;
        end else begin
            for (int k = 0; k < N; k++)
                if (wr_en[k])
                    ptr_q[wr_set][k] <= IW'(mpsel_pkg::wrap_add(int'(ptr_q[wr_set][k]), 1, N));
        end
    end

    // Multiplex the selected set onto the flat read bus.
    always_comb begin
        for (int k = 0; k < N; k++)
            rd_ptr[k*IW +: IW] = ptr_q[rd_set][k];
    end

endmodule

// File: rtl/mpsel_delay.sv
// Module: fixed-depth register channel that models the request path.
// Assumes DEPTH >= 1. Every stage clears to zero on reset, so all-zero means empty.
module mpsel_delay #(
    parameter int W     = 8,
    parameter int DEPTH = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg_q [DEPTH];

    // Shift the payload one stage per slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++)
                stg_q[k] <= '0;
        end else begin
            stg_q[0] <= din;
            for (int k = 1; k < DEPTH; k++)
                stg_q[k] <= stg_q[k-1];
        end
    end

    assign dout = stg_q[DEPTH-1];

endmodule

// File: rtl/mpsel_xbar_sched.sv
// Module: input/output selector pair with RHO pointer sets.
// Each cycle is one slot. Requests use set (slot mod RHO), travel RHO-1
// register stages, and are answered with the grant set of the same tag.
// The results update only the tagged set. Assumes N >= 2 and RHO >= 2.
module mpsel_xbar_sched #(
    parameter int N   = 4,
    parameter int RHO = 4,
    localparam int IW = $clog2(N),
    localparam int SW = $clog2(RHO)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N*N-1:0]  occ_i,
    output logic [N-1:0]    req_vld_o,
    output logic [N*IW-1:0] req_tgt_o,
    output logic [SW-1:0]   req_set_o,
    output logic [N-1:0]    gnt_vld_o,
    output logic [N*IW-1:0] gnt_src_o,
    output logic [SW-1:0]   gnt_set_o,
    output logic [N-1:0]    won_o
);

    localparam int PW    = SW + N + N*IW;
    localparam int DEPTH = RHO - 1;

    logic [SW-1:0]   slot_q;
    logic [N*IW-1:0] r_ptr;
    logic [N*IW-1:0] g_ptr;
    logic [PW-1:0]   chan_out;
    logic [SW-1:0]   d_set;
    logic [N-1:0]    d_vld;
    logic [N*IW-1:0] d_tgt;
    logic [N-1:0]    col [N];
    logic [N-1:0]    won;

    // Slot counter: picks the active pointer set.
    always_ff @(posedge clk) begin
        if (!rst_n)
            slot_q <= '0;
        else
            slot_q <= (slot_q == SW'(RHO-1)) ? '0 : slot_q + SW'(1);
    end

    assign req_set_o = slot_q;

    // Request pointers: read the active set, update the returning set.
    mpsel_ptr_bank #(.N(N), .RHO(RHO), .IW(IW), .SW(SW)) in_bank_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_set (slot_q),
        .rd_ptr (r_ptr),
        .wr_set (d_set),
        .wr_en  (won)
    );

    // One shared picker per input, fed by the selected set.
    for (genvar gi = 0; gi < N; gi++) begin : g_in_sel
        mpsel_rr_pick #(.N(N), .IW(IW)) pick_i (
            .req (occ_i[gi*N +: N]),
            .ptr (r_ptr[gi*IW +: IW]),
            .hit (req_vld_o[gi]),
            .idx (req_tgt_o[gi*IW +: IW])
        );
    end

    // Channel of RHO-1 stages carrying the tag with the requests.
    mpsel_delay #(.W(PW), .DEPTH(DEPTH)) chan_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({slot_q, req_vld_o, req_tgt_o}),
        .dout  (chan_out)
    );

    assign {d_set, d_vld, d_tgt} = chan_out;
    assign gnt_set_o = d_set;

    // Regroup the arriving requests per target output.
    always_comb begin
        for (int o = 0; o < N; o++)
            for (int i = 0; i < N; i++)
                col[o][i] = d_vld[i] && (d_tgt[i*IW +: IW] == IW'(o));
    end

    // Grant pointers: read and update the tagged set.
    mpsel_ptr_bank #(.N(N), .RHO(RHO), .IW(IW), .SW(SW)) out_bank_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_set (d_set),
        .rd_ptr (g_ptr),
        .wr_set (d_set),
        .wr_en  (gnt_vld_o)
    );

    // One shared picker per output, fed by the tagged set.
    for (genvar go = 0; go < N; go++) begin : g_out_sel
        mpsel_rr_pick #(.N(N), .IW(IW)) pick_o (
            .req (col[go]),
            .ptr (g_ptr[go*IW +: IW]),
            .hit (gnt_vld_o[go]),
            .idx (gnt_src_o[go*IW +: IW])
        );
    end

    // Mark the inputs whose returning request was granted.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            won[i] = 1'b0;
            for (int o = 0; o < N; o++)
                if (gnt_vld_o[o] && gnt_src_o[o*IW +: IW] == IW'(i))
                    won[i] = 1'b1;
        end
    end

    assign won_o = won;

endmodule

// File: rtl/mpsel_xbar_sched_chk.sv
// Module: assertion checker bound to mpsel_xbar_sched. Sees only its ports.
module mpsel_xbar_sched_chk #(
    parameter int N   = 4,
    parameter int RHO = 4,
    localparam int IW = $clog2(N),
    localparam int SW = $clog2(RHO)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N*N-1:0]  occ_i,
    input logic [N-1:0]    req_vld_o,
    input logic [N*IW-1:0] req_tgt_o,
    input logic [SW-1:0]   req_set_o,
    input logic [N-1:0]    gnt_vld_o,
    input logic [N*IW-1:0] gnt_src_o,
    input logic [SW-1:0]   gnt_set_o,
    input logic [N-1:0]    won_o
);

    logic [SW-1:0] tag_exp;
    logic [N-1:0]  hit_by [N];

    // Tag expected on arriving requests: current set advanced by one, cyclically.
    always_comb tag_exp = (req_set_o == SW'(RHO-1)) ? '0 : req_set_o + SW'(1);

    // For each input, which outputs granted it this slot.
    always_comb begin
        for (int i = 0; i < N; i++)
            for (int o = 0; o < N; o++)
                hit_by[i][o] = gnt_vld_o[o] && (gnt_src_o[o*IW +: IW] == IW'(i));
    end

    p_set_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_set_o != SW'(RHO-1)) |=> (req_set_o == $past(req_set_o) + SW'(1)));

    p_set_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_set_o == SW'(RHO-1)) |=> (req_set_o == '0));

    p_gnt_tag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt_vld_o) |-> (gnt_set_o == tag_exp));

    p_win_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(won_o) == $countones(gnt_vld_o));

    for (genvar gi = 0; gi < N; gi++) begin : g_per_in
        p_req_occupied_r3: assert property (@(posedge clk) disable iff (!rst_n)
            req_vld_o[gi] |-> occ_i[gi*N + int'(req_tgt_o[gi*IW +: IW])]);

        p_req_when_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
            req_vld_o[gi] == (|occ_i[gi*N +: N]));

        p_one_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(hit_by[gi]) <= 1);
    end

endmodule

bind mpsel_xbar_sched mpsel_xbar_sched_chk #(.N(N), .RHO(RHO)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .occ_i     (occ_i),
    .req_vld_o (req_vld_o),
    .req_tgt_o (req_tgt_o),
    .req_set_o (req_set_o),
    .gnt_vld_o (gnt_vld_o),
    .gnt_src_o (gnt_src_o),
    .gnt_set_o (gnt_set_o),
    .won_o     (won_o)
);

// File: tb/mpsel_xbar_sched_tb.sv
// Scoreboard bench: the driver computes the expected requests from a model
// with RHO pointer sets and pushes them into a channel queue; the monitor pops
// each item RHO-1 slots later, predicts the grants, and updates the model.
module mpsel_xbar_sched_tb_top;

    localparam int N          = 4;
    localparam int RHO        = 4;
    localparam int IW         = $clog2(N);
    localparam int SW         = $clog2(RHO);
    localparam int CLK_PERIOD = 10;

    typedef struct {
        int       set;
        bit [N-1:0] vld;
        int       tgt [N];
    } item_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N*N-1:0]  occ_i = '0;
    logic [N-1:0]    req_vld_o;
    logic [N*IW-1:0] req_tgt_o;
    logic [SW-1:0]   req_set_o;
    logic [N-1:0]    gnt_vld_o;
    logic [N*IW-1:0] gnt_src_o;
    logic [SW-1:0]   gnt_set_o;
    logic [N-1:0]    won_o;

    int    checks = 0;
    int    errors = 0;
    int    m_r [RHO][N];
    int    m_g [RHO][N];
    int    m_slot = 0;
    item_t chan [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mpsel_xbar_sched #(.N(N), .RHO(RHO)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .occ_i     (occ_i),
        .req_vld_o (req_vld_o),
        .req_tgt_o (req_tgt_o),
        .req_set_o (req_set_o),
        .gnt_vld_o (gnt_vld_o),
        .gnt_src_o (gnt_src_o),
        .gnt_set_o (gnt_set_o),
        .won_o     (won_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Reset the design and the model together, then release before a slot.
    task automatic do_reset();
        item_t pad;
        @(negedge clk);
        rst_n = 1'b0;
        occ_i = '0;
        repeat (3) @(negedge clk);
        // R1: while reset is held, no grant is produced and set 0 is selected.
        chk(gnt_vld_o == '0, "R1 no grant in reset", int'(gnt_vld_o), 0);
        chk(req_set_o == '0, "R1 set zero in reset", int'(req_set_o), 0);
        for (int s = 0; s < RHO; s++)
            for (int k = 0; k < N; k++) begin
                m_r[s][k] = 0;
                m_g[s][k] = 0;
            end
        m_slot = 0;
        chan.delete();
        pad.set = 0;
        pad.vld = '0;
        for (int k = 0; k < N; k++) pad.tgt[k] = 0;
        for (int k = 0; k < RHO-1; k++) chan.push_back(pad);
        @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    // Driver: apply one slot of occupancy, check the requests, push the expected item.
    task automatic run_slot(input logic [N*N-1:0] occ);
        item_t it;
        @(negedge clk);
        occ_i = occ;
        #1;
        it.set = m_slot;
        it.vld = '0;
        chk(int'(req_set_o) == m_slot, "R2 active set", int'(req_set_o), m_slot);
        for (int i = 0; i < N; i++) begin
            it.tgt[i] = 0;
            for (int k = 0; k < N; k++) begin
                int j;
                j = (m_r[m_slot][i] + k) % N;
                if (!it.vld[i] && occ[i*N + j]) begin
                    it.vld[i] = 1'b1;
                    it.tgt[i] = j;
                end
            end
            chk(req_vld_o[i] == it.vld[i], "R3 request valid", int'(req_vld_o[i]), int'(it.vld[i]));
            if (it.vld[i])
                chk(int'(req_tgt_o[i*IW +: IW]) == it.tgt[i], "R3/R9 request target",
                    int'(req_tgt_o[i*IW +: IW]), it.tgt[i]);
        end
        chan.push_back(it);
        m_slot = (m_slot + 1) % RHO;
    endtask

    // Monitor: pop the item that reaches the output side, predict and compare grants.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && chan.size() == RHO) begin
                item_t  it;
                bit [N-1:0] ev;
                int     es [N];
                bit [N-1:0] ew;
                it = chan.pop_front();
                ew = '0;
                for (int o = 0; o < N; o++) begin
                    ev[o] = 1'b0;
                    es[o] = 0;
                    for (int k = 0; k < N; k++) begin
                        int i;
                        i = (m_g[it.set][o] + k) % N;
                        if (!ev[o] && it.vld[i] && it.tgt[i] == o) begin
                            ev[o] = 1'b1;
                            es[o] = i;
                        end
                    end
                    if (ev[o]) ew[es[o]] = 1'b1;
                    chk(gnt_vld_o[o] == ev[o], "R1/R5 grant valid", int'(gnt_vld_o[o]), int'(ev[o]));
                    if (ev[o])
                        chk(int'(gnt_src_o[o*IW +: IW]) == es[o], "R5/R7 granted input",
                            int'(gnt_src_o[o*IW +: IW]), es[o]);
                end
                if (|ev)
                    chk(int'(gnt_set_o) == it.set, "R4 grant set tag", int'(gnt_set_o), it.set);
                for (int i = 0; i < N; i++) begin
                    int cnt;
                    cnt = 0;
                    for (int o = 0; o < N; o++)
                        if (gnt_vld_o[o] && int'(gnt_src_o[o*IW +: IW]) == i) cnt++;
                    chk(cnt <= 1, "R6 grants per input", cnt, 1);
                    chk(won_o[i] == ew[i], "R8 input won", int'(won_o[i]), int'(ew[i]));
                end
                for (int o = 0; o < N; o++)
                    if (ev[o]) m_g[it.set][o] = (m_g[it.set][o] + 1) % N;
                for (int i = 0; i < N; i++)
                    if (ew[i]) m_r[it.set][i] = (m_r[it.set][i] + 1) % N;
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    // Stimulus: saturated, hot-spot, permutation, random, empty, and mid-run reset.
    initial begin
        logic [N*N-1:0] pat;
        do_reset();
        for (int n = 0; n < 40; n++) run_slot('1);
        pat = '0;
        for (int i = 0; i < N; i++) pat[i*N + 0] = 1'b1;
        for (int n = 0; n < 30; n++) run_slot(pat);
        for (int n = 0; n < 30; n++) begin
            pat = '0;
            for (int i = 0; i < N; i++) pat[i*N + ((i + n) % N)] = 1'b1;
            run_slot(pat);
        end
        for (int n = 0; n < 200; n++) begin
            for (int b = 0; b < N*N; b++) pat[b] = ($urandom % 3) != 0;
            run_slot(pat);
        end
        for (int n = 0; n < 10; n++) run_slot('0);
        do_reset();
        for (int n = 0; n < 40; n++) run_slot('1);
        for (int n = 0; n < 100; n++) begin
            for (int b = 0; b < N*N; b++) pat[b] = ($urandom % 2) != 0;
            run_slot(pat);
        end
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule